// File: doc/BRIEF.md
# Zero-Suppressed Hit Frame Packer

Once per machine cycle this block takes a hit flag and a 4-bit arrival-time code for each of 48 detector channels. It turns them into one 112-bit frame for a shared serial uplink. The frame carries a 16-bit header, the full hit map, and the time codes of hit channels only, up to 12 of them. Time codes from channels without a hit are discarded. When more than 12 channels fire, the codes of the highest-numbered hit channels are dropped for that cycle alone, and the header records that this happened and how many codes were lost.

The finished frame goes through a delay whose length is chosen with a 4-bit setting. Several packers that share one uplink can then be lined up on the same bunch crossing. Changing the setting empties the delay, so a stale frame is never sent at the new latency.

Frame layout: bits [47:0] hold the packed codes, bits [95:48] hold the hit map (channel c at bit 48+c), and bits [111:96] hold the header. In the header, bits [107:96] are the bunch count, bit [108] is the overflow flag and bits [111:109] are the lost-code count.

Top module: `zs_frame_packer`

## Requirements
- R1: Bits [95:48] of each frame equal the 48-bit hit vector of the cycle the frame was built from, with channel c at bit 48+c. All hit bits are present even when codes were dropped.
- R2: The code of channel c is tdc_in[4c+3:4c]. The codes of hit channels are packed in ascending channel order: the lowest hit channel goes in bits [3:0], the next in [7:4], and so on.
- R3: The codes of channels whose hit bit is 0 never reach the frame: changing them leaves the frame unchanged. Nibbles of bits [47:0] that hold no kept code are zero.
- R4: If more than 12 channels are hit, only the 12 lowest hit channels keep their codes and header bit [108] is 1. Otherwise bit [108] is 0.
- R5: Header bits [111:109] hold the number of hit channels beyond 12, saturated at 7. The value is 0 when 12 or fewer channels are hit.
- R6: Header bits [107:96] hold a bunch count. It is 0 in the first frame built after reset, rises by 1 for every following frame, and wraps from 4095 to 0.
- R7: With cfg_depth held at D (0 to 15), the frame built from the inputs sampled at clock edge k appears on frame_out right after edge k+D.
- R8: At an edge where cfg_depth differs from the depth in use, the new depth is adopted and every frame in the delay is discarded. For a new depth D > 0, frame_out is then all zero for the next D cycles.
- R9: While rst_n is low, frame_out is all zero.
- R10: Dropping codes in one cycle has no effect on later cycles: each frame depends only on its own cycle's inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | 48 | Hit flag per channel |
| tdc_in | input | 192 | Arrival-time code per channel, 4 bits each, channel c at [4c+3:4c] |
| cfg_depth | input | 4 | Extra delay in cycles, 0 to 15 |
| frame_out | output | 112 | Delayed output frame |

## Verification
The bench builds the packer with its default parameters: 48 channels, 4-bit codes, 12 kept codes, a 12-bit bunch count, a 3-bit loss count and a 4-bit depth. At these sizes a fully hit cycle loses 36 codes, well past the saturation at 7. The bunch count wraps within about 4,100 cycles. Every depth from 0 to the maximum of 15 can be selected, including changes made in the middle of a stream.

// File: rtl/zsp_pkg.sv
package zsp_pkg;
  localparam int unsigned DEF_CHANNELS = 48;
  localparam int unsigned DEF_CODE_W   = 4;
  localparam int unsigned DEF_KEEP     = 12;
  localparam int unsigned DEF_BX_W     = 12;
  localparam int unsigned DEF_LOSS_W   = 3;
  localparam int unsigned DEF_DEPTH_W  = 4;

  // number of entries above a cap, clipped at a ceiling
  function automatic int unsigned clip_excess(input int unsigned total,
                                              input int unsigned cap,
                                              input int unsigned ceiling);
    int unsigned over;
    over = (total > cap) ? total - cap : 0;
    return (over > ceiling) ? ceiling : over;
  endfunction
endpackage

// File: rtl/zsp_compactor.sv
module zsp_compactor #(
  parameter int unsigned N_CH   = zsp_pkg::DEF_CHANNELS,
  parameter int unsigned CODE_W = zsp_pkg::DEF_CODE_W,
  parameter int unsigned KEEP   = zsp_pkg::DEF_KEEP,
  parameter int unsigned LOSS_W = zsp_pkg::DEF_LOSS_W,
  localparam int unsigned FIELD_W = KEEP * CODE_W,
  localparam int unsigned CNT_W   = $clog2(N_CH + 1)
) (
  input  logic [N_CH-1:0]        hit_vec,
  input  logic [N_CH*CODE_W-1:0] code_vec,
  output logic [FIELD_W-1:0]     packed_codes,
  output logic [CNT_W-1:0]       hit_total,
  output logic                   overflow,
  output logic [LOSS_W-1:0]      lost
);
  localparam int unsigned LOSS_MAX = (1 << LOSS_W) - 1;

  // walk channels upward, dropping codes once the field is full
  always_comb begin
    int kept;
    int seen;
    kept = 0;
    seen = 0;
    packed_codes = '0;
    for (int c = 0; c < int'(N_CH); c++) begin
      if (hit_vec[c]) begin
        if (kept < int'(KEEP)) begin
          packed_codes[kept*CODE_W +: CODE_W] = code_vec[c*CODE_W +: CODE_W];
          kept++;
        end
        seen++;
      end
    end
    hit_total = CNT_W'(seen);
  end

  assign overflow = (32'(hit_total) > KEEP);
  assign lost     = LOSS_W'(zsp_pkg::clip_excess(32'(hit_total), KEEP, LOSS_MAX));
endmodule

// File: rtl/zsp_stamp.sv
module zsp_stamp #(
  parameter int unsigned BX_W   = zsp_pkg::DEF_BX_W,
  parameter int unsigned LOSS_W = zsp_pkg::DEF_LOSS_W,
  localparam int unsigned HDR_W = BX_W + 1 + LOSS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              overflow,
  input  logic [LOSS_W-1:0] lost,
  output logic [HDR_W-1:0]  header
);
  logic [BX_W-1:0] bx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bx_q <= '0;
    else        bx_q <= bx_q + 1'b1;
  end

  assign header = {lost, overflow, bx_q};

  AST_BX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> bx_q == BX_W'($past(bx_q) + 1'b1)); // R6
endmodule

// File: rtl/zsp_delay_line.sv
module zsp_delay_line #(
  parameter int unsigned W       = 112,
  parameter int unsigned DEPTH_W = zsp_pkg::DEF_DEPTH_W,
  localparam int unsigned MAX_DEPTH = (1 << DEPTH_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic [W-1:0]       din,
  output logic [W-1:0]       dout
);
  logic [DEPTH_W-1:0] depth_q;
  logic [DEPTH_W-1:0] tap;
  logic               flush;
  logic [W-1:0]       slot_q [MAX_DEPTH];

  assign flush = (cfg_depth != depth_q);
  assign tap   = depth_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     depth_q <= '0;
    else if (flush) depth_q <= cfg_depth;
  end

  generate
    for (genvar i = 0; i < int'(MAX_DEPTH); i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     slot_q[i] <= '0;
        else if (flush) slot_q[i] <= '0;
        else if (i == 0) slot_q[i] <= din;
        else            slot_q[i] <= slot_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = (depth_q == '0) ? din : slot_q[tap];

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && cfg_depth != '0) |=> dout == '0); // R8
  AST_DEPTH_ADOPT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> depth_q == $past(cfg_depth)); // R8
endmodule

// File: rtl/zs_frame_packer.sv
module zs_frame_packer #(
  parameter int unsigned N_CH    = zsp_pkg::DEF_CHANNELS,
  parameter int unsigned CODE_W  = zsp_pkg::DEF_CODE_W,
  parameter int unsigned KEEP    = zsp_pkg::DEF_KEEP,
  parameter int unsigned BX_W    = zsp_pkg::DEF_BX_W,
  parameter int unsigned LOSS_W  = zsp_pkg::DEF_LOSS_W,
  parameter int unsigned DEPTH_W = zsp_pkg::DEF_DEPTH_W,
  localparam int unsigned FIELD_W = KEEP * CODE_W,
  localparam int unsigned HDR_W   = BX_W + 1 + LOSS_W,
  localparam int unsigned FRAME_W = HDR_W + N_CH + FIELD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        hit_in,
  input  logic [N_CH*CODE_W-1:0] tdc_in,
  input  logic [DEPTH_W-1:0]     cfg_depth,
  output logic [FRAME_W-1:0]     frame_out
);
  localparam int unsigned CNT_W   = $clog2(N_CH + 1);
  localparam int unsigned HIT_LSB = FIELD_W;

  logic [FIELD_W-1:0] field;
  logic [CNT_W-1:0]   hit_total;
  logic               overflow;
  logic [LOSS_W-1:0]  lost;
  logic [HDR_W-1:0]   header;
  logic [FRAME_W-1:0] frame_q;

  zsp_compactor #(.N_CH(N_CH), .CODE_W(CODE_W), .KEEP(KEEP), .LOSS_W(LOSS_W)) u_compactor (
    .hit_vec(hit_in), .code_vec(tdc_in), .packed_codes(field),
    .hit_total(hit_total), .overflow(overflow), .lost(lost));

  zsp_stamp #(.BX_W(BX_W), .LOSS_W(LOSS_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .overflow(overflow), .lost(lost), .header(header));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= {header, hit_in, field};
  end

  zsp_delay_line #(.W(FRAME_W), .DEPTH_W(DEPTH_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .din(frame_q), .dout(frame_out));

  AST_HIT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> frame_q[HIT_LSB +: N_CH] == $past(hit_in)); // R1
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    overflow == ($countones(hit_in) > KEEP)); // R4
  AST_IDLE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_in == '0) |-> field == '0); // R3
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    32'(hit_total) == $countones(hit_in)); // R5
endmodule

// File: tb/zs_frame_packer_bench.sv
module zs_frame_packer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [47:0]  hit_in = '0;
  logic [191:0] tdc_in = '0;
  logic [3:0]   cfg_depth = '0;
  logic [111:0] frame_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model state
  logic [111:0] hist [int];
  int n = 0;
  int dq = 0;
  int flush_e = 0;
  int bx = 0;
  string ctx = "";

  always #10 clk = ~clk;

  zs_frame_packer u_zs_frame_packer (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .tdc_in(tdc_in),
    .cfg_depth(cfg_depth), .frame_out(frame_out));

  function automatic logic [111:0] model_frame(logic [47:0] h, logic [191:0] t, int stamp);
    logic [47:0] f;
    int k;
    int tot;
    int drop;
    f = '0; k = 0; tot = 0;
    for (int c = 0; c < 48; c++) begin
      if (h[c]) begin
        tot++;
        if (tot <= 12) begin
          f[4*k +: 4] = t[4*c +: 4];
          k++;
        end
      end
    end
    drop = (tot > 12) ? tot - 12 : 0;
    if (drop > 7) drop = 7;
    return {3'(drop), (tot > 12), 12'(stamp), h, f};
  endfunction

  task automatic chk(input string tag, input logic [111:0] act, input logic [111:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s%s actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  task automatic compare(input logic [111:0] exp);
    string pre;
    pre = (dq > 0) ? "R7/" : "";
    if (dq > 0 && n - dq < flush_e) begin
      chk("R8", frame_out, exp);
    end else begin
      chk({pre, "R2"}, 112'(frame_out[47:0]),   112'(exp[47:0]));
      chk({pre, "R1"}, 112'(frame_out[95:48]),  112'(exp[95:48]));
      chk({pre, "R6"}, 112'(frame_out[107:96]), 112'(exp[107:96]));
      chk({pre, "R4"}, 112'(frame_out[108]),    112'(exp[108]));
      chk({pre, "R5"}, 112'(frame_out[111:109]),112'(exp[111:109]));
    end
  endtask

  task automatic step(input logic [47:0] h, input logic [191:0] t, input logic [3:0] d);
    logic [111:0] frm;
    logic [111:0] exp;
    hit_in = h; tdc_in = t; cfg_depth = d;
    @(posedge clk);
    frm = model_frame(h, t, bx);
    hist[n] = frm;
    bx = (bx + 1) % 4096;
    if (int'(d) != dq) begin
      dq = int'(d);
      flush_e = n;
    end
    if (dq == 0) exp = frm;
    else if (n - dq >= flush_e) exp = hist[n - dq];
    else exp = '0;
    @(negedge clk);
    compare(exp);
    n++;
  endtask

  function automatic logic [191:0] rnd_codes();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [47:0] rnd_hits();
    logic [63:0] a;
    logic [63:0] b;
    a = {$urandom, $urandom};
    b = {$urandom, $urandom};
    return 48'(a & b);
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [47:0] keep_h;
    logic [191:0] t1;
    logic [191:0] t2;
    logic [47:0] saved;
    repeat (3) @(negedge clk);
    chk("R9", frame_out, '0);
    hit_in = '1; tdc_in = '1;
    @(negedge clk);
    chk("R9", frame_out, '0);
    hit_in = '0; tdc_in = '0;
    rst_n = 1'b1;

    // depth 0 patterns
    step('0, rnd_codes(), 4'd0);
    step(48'h8000_0000_0000, rnd_codes(), 4'd0);
    step(48'h0000_0000_0FFF, rnd_codes(), 4'd0);       // exactly 12
    step(48'h0000_0000_1FFF, rnd_codes(), 4'd0);       // 13 hits, R4
    step('1, rnd_codes(), 4'd0);                       // R5 saturation
    step(48'h0007_0000_FFFF, rnd_codes(), 4'd0);       // 19 hits
    step(48'h8000_0000_3FFF, rnd_codes(), 4'd0);       // 15 hits, loss 3
    ctx = " (R10)";
    step(48'h0000_0400_0001, rnd_codes(), 4'd0);
    ctx = "";

    // R3: codes of unhit channels are ignored
    keep_h = 48'h0100_0020_0004;
    t1 = rnd_codes();
    t2 = ~t1;
    t2[8 +: 4]   = t1[8 +: 4];
    t2[84 +: 4]  = t1[84 +: 4];
    t2[160 +: 4] = t1[160 +: 4];
    step(keep_h, t1, 4'd0);
    saved = frame_out[47:0];
    step(keep_h, t2, 4'd0);
    chk("R3", 112'(frame_out[47:0]), 112'(saved));
    chk("R3", 112'(frame_out[47:12]), 112'(0));

    // R7/R8: depth changes
    for (int i = 0; i < 20; i++) step(rnd_hits(), rnd_codes(), 4'd3);
    for (int i = 0; i < 40; i++) step(rnd_hits(), rnd_codes(), 4'd15);
    for (int i = 0; i < 10; i++) step(rnd_hits(), rnd_codes(), 4'd1);
    for (int i = 0; i < 10; i++) step(rnd_hits(), rnd_codes(), 4'd0);

    // long run, bunch count wrap and random depth changes
    begin
      logic [3:0] d;
      d = 4'd5;
      for (int i = 0; i < 4300; i++) begin
        if (i % 250 == 0) d = 4'($urandom_range(0, 15));
        if (i % 7 == 0) step({$urandom, $urandom} , rnd_codes(), d);
        else step(rnd_hits(), rnd_codes(), d);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule